// File: doc/BRIEF.md
# Multichannel Serial Result Readout Engine

This block takes sixteen conversion results, each loaded at once on a parallel bus with a one-cycle strobe in the master-clock domain, and sends them out serially under an external data clock. The results can leave as one long stream on a single output, or as four streams of four words each on four outputs. Before it is sent, each word is cut to 16, 14 or 12 bits. An active-low data-valid flag tells the reader when a new set is waiting. A second strobe loads a 16-bit configuration word in place of results, so that it can be read back.

In single-output mode, several devices can be chained. The upstream device's serial output feeds the chain input, and once the local bits are out, the chained bits follow with no gap. The data clock is sampled inside the master-clock domain through a two-flop synchronizer. For this reason, each phase of the data clock must last at least four master-clock cycles. If a load arrives while a readout is still running, it restarts the readout with the new data and raises an overrun flag.

Top module: `readout_serializer`

## Requirements
- R1: After reset, `dvalid_n` is 1, all `dout` bits are 0 and `overrun` is 0.
- R2: `dvalid_n` goes to 0 on the first rising `clk` edge that samples `ld_stb` or `cfg_stb` high. At that point the first output bit of the new set is already on `dout`.
- R3: `dvalid_n` returns to 1 on the first falling edge of `dclk` after it went low. It then stays at 1 until the next load.
- R4: With `par_mode`=0, channel k is `ld_words[16k +: 16]` (k from 0). The sixteen channels leave on `dout[0]` in channel order, MSB first. Each falling edge of `dclk` advances the stream by one bit within 3 `clk` edges. `dout[3:1]` stay 0.
- R5: With `par_mode`=1, `dout[L]` carries channels 4L to 4L+3 in order, MSB first. All four outputs advance together on each falling edge of `dclk`.
- R6: `res_sel` selects the word width: 00 gives 16 bits, 01 gives 14 bits (two LSBs dropped), and 10 or 11 give 12 bits (four LSBs dropped). Dropped bits take no clock slot, so the next word follows at once.
- R7: With `par_mode`=0, `chain_in` is sampled on each rising edge of `dclk`. The bit sampled on rising edge j (from 0) appears on `dout[0]` as stream bit N+j, where N is the number of local bits.
- R8: With `par_mode`=1, `chain_in` has no effect. Once the local bits are out, every `dout` bit reads 0.
- R9: `cfg_stb` loads `cfg_word`, MSB first on `dout[0]`, whatever the resolution, with `dout[3:1]` at 0. A results load that comes before the readback is read replaces it completely.
- R10: A load while `dvalid_n`=1 and local bits remain unsent sets `overrun` and restarts the readout from the new data. Any other load clears `overrun`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_stb | input | 1 | One-cycle strobe that loads a new result set |
| ld_words | input | 256 | Sixteen 16-bit results, channel k in bits [16k+15:16k] |
| cfg_stb | input | 1 | One-cycle strobe that loads the configuration readback word |
| cfg_word | input | 16 | Configuration word to be read back |
| par_mode | input | 1 | 1 = four outputs, 0 = single output; captured at load |
| res_sel | input | 2 | Word-width select; captured at load |
| dclk | input | 1 | Data clock from the reader |
| chain_in | input | 1 | Serial data from an upstream device |
| dout | output | 4 | Serial data outputs |
| dvalid_n | output | 1 | New data waiting, active low |
| overrun | output | 1 | The last load cut short a readout |

## Verification
- `dvalid_n` is checked at the first falling `clk` edge after the strobe. By then, the rising edge that is due to lower it has passed.
- After a falling edge of `dclk`, a new `dout` bit is due within three `clk` edges: two synchronizer flops, then the shift register. The bench holds each `dclk` phase for four `clk` cycles and samples `dout` at the end of the low phase.
- The chain input is set before `dclk` rises and held until the next step. Its bit is therefore captured in the high phase, and the bench expects it N bits later in the stream.
- `overrun` is due one edge after the load and is checked at the falling edge right after the strobe.

// File: rtl/readout_serializer.sv
module readout_serializer #(
  parameter int CHANNELS = 16,
  parameter int WORD_W   = 16,
  parameter int LANES    = 4,
  parameter int MID_DROP = 2,
  parameter int LOW_DROP = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ld_stb,
  input  logic [CHANNELS*WORD_W-1:0] ld_words,
  input  logic                       cfg_stb,
  input  logic [WORD_W-1:0]          cfg_word,
  input  logic                       par_mode,
  input  logic [1:0]                 res_sel,
  input  logic                       dclk,
  input  logic                       chain_in,
  output logic [LANES-1:0]           dout,
  output logic                       dvalid_n,
  output logic                       overrun
);
  localparam int TOTAL    = CHANNELS * WORD_W;
  localparam int PER_LANE = CHANNELS / LANES;
  localparam int LANE_W   = PER_LANE * WORD_W;
  localparam int CNT_W    = $clog2(TOTAL + 1);
  localparam int IDX_W    = $clog2(TOTAL);

  logic [TOTAL-1:0] sreg, img, sh;
  logic [CNT_W-1:0] nbits_q, cnt, ld_bits;
  logic [IDX_W-1:0] ins_idx;
  logic [2:0]       dsync;
  logic [1:0]       csync;
  logic             par_q, pend, rise, fall, ld_any, busy;

  assign ld_any  = ld_stb | cfg_stb;
  assign rise    = dsync[1] & ~dsync[2];
  assign fall    = ~dsync[1] & dsync[2];
  assign busy    = dvalid_n & (cnt < nbits_q);
  assign ins_idx = IDX_W'(TOTAL - int'(nbits_q));

  always_comb begin : pack
    int drop;
    int wbits;
    logic [TOTAL-1:0]  acc;
    logic [LANE_W-1:0] lacc;
    acc  = '0;
    lacc = '0;
    case (res_sel)
      2'b00:   drop = 0;
      2'b01:   drop = MID_DROP;
      default: drop = LOW_DROP;
    endcase
    wbits   = WORD_W - drop;
    img     = '0;
    ld_bits = '0;
    if (ld_stb) begin
      if (par_mode) begin
        for (int l = 0; l < LANES; l++) begin
          lacc = '0;
          for (int j = 0; j < PER_LANE; j++)
            lacc = (lacc << wbits) |
                   LANE_W'(ld_words[(l*PER_LANE+j)*WORD_W +: WORD_W] >> drop);
          img[(LANES-1-l)*LANE_W +: LANE_W] = lacc << (LANE_W - PER_LANE*wbits);
        end
        ld_bits = CNT_W'(PER_LANE * wbits);
      end else begin
        for (int k = 0; k < CHANNELS; k++)
          acc = (acc << wbits) | TOTAL'(ld_words[k*WORD_W +: WORD_W] >> drop);
        img     = acc << (TOTAL - CHANNELS*wbits);
        ld_bits = CNT_W'(CHANNELS * wbits);
      end
    end else begin
      img[TOTAL-1 -: WORD_W] = cfg_word;
      ld_bits = CNT_W'(WORD_W);
    end
  end

  always_comb begin : step
    sh = '0;
    if (par_q) begin
      for (int l = 0; l < LANES; l++)
        sh[l*LANE_W +: LANE_W] = {sreg[l*LANE_W +: LANE_W-1], 1'b0};
    end else begin
      sh = {sreg[TOTAL-2:0], 1'b0};
      if (nbits_q != '0) sh[ins_idx] = pend;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsync    <= '0;
      csync    <= '0;
      pend     <= 1'b0;
      sreg     <= '0;
      par_q    <= 1'b0;
      nbits_q  <= '0;
      cnt      <= '0;
      dvalid_n <= 1'b1;
      overrun  <= 1'b0;
    end else begin
      dsync <= {dsync[1:0], dclk};
      csync <= {csync[0], chain_in};
      if (rise) pend <= csync[1];
      if (ld_any) begin
        sreg     <= img;
        par_q    <= par_mode;
        nbits_q  <= ld_bits;
        cnt      <= '0;
        dvalid_n <= 1'b0;
        overrun  <= busy;
      end else if (fall) begin
        sreg     <= sh;
        dvalid_n <= 1'b1;
        if (cnt < nbits_q) cnt <= cnt + 1'b1;
      end
    end
  end

  assign dout[0] = sreg[TOTAL-1];
  for (genvar l = 1; l < LANES; l++) begin : g_lane
    assign dout[l] = par_q & sreg[(LANES-l)*LANE_W-1];
  end

  assert_dvalid_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_any |=> !dvalid_n);
  assert_dvalid_rise_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dvalid_n) |-> $past(fall));
  assert_dvalid_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dvalid_n && !ld_any) |=> dvalid_n);
  assert_dout_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && !ld_any) |=> $stable(dout));
  assert_overrun_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_any && busy) |=> overrun);
  assert_overrun_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_any && !busy) |=> !overrun);
  assert_overrun_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_any |=> $stable(overrun));
endmodule

// File: tb/readout_serializer_tb.sv
module readout_serializer_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ld_stb = 1'b0, cfg_stb = 1'b0, par_mode = 1'b0, dclk = 1'b0, chain_in = 1'b0;
  logic [255:0] ld_words = '0;
  logic [15:0]  cfg_word = '0;
  logic [1:0]   res_sel = 2'b00;
  logic [3:0]   dout;
  logic         dvalid_n, overrun;

  logic [15:0]  wv [16];
  logic [3:0]   cap [512];
  int           n_chk = 0, n_fail = 0;
  bit           done = 0;

  always #10 clk = ~clk;

  readout_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_words(ld_words),
    .cfg_stb(cfg_stb), .cfg_word(cfg_word), .par_mode(par_mode), .res_sel(res_sel),
    .dclk(dclk), .chain_in(chain_in), .dout(dout), .dvalid_n(dvalid_n), .overrun(overrun));

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_words(input logic [15:0] seed);
    for (int k = 0; k < 16; k++) wv[k] = 16'((seed * (k + 3)) ^ (k << 9) ^ 16'h5a3c);
  endtask

  task automatic load_results(input logic par, input logic [1:0] res);
    @(negedge clk);
    for (int k = 0; k < 16; k++) ld_words[k*16 +: 16] = wv[k];
    par_mode = par; res_sel = res; ld_stb = 1'b1;
    @(negedge clk);
    ld_stb = 1'b0;
    check("R2", "dvalid_n after results load", 64'(dvalid_n), 64'd0);
  endtask

  task automatic load_cfg(input logic [15:0] w);
    @(negedge clk);
    cfg_word = w; cfg_stb = 1'b1;
    @(negedge clk);
    cfg_stb = 1'b0;
    check("R2", "dvalid_n after config load", 64'(dvalid_n), 64'd0);
  endtask

  task automatic read_bits(input int n, input logic [31:0] chain_src);
    for (int i = 0; i < n; i++) begin
      cap[i] = dout;
      chain_in = (i < 32) ? chain_src[31-i] : 1'b0;
      dclk = 1'b1;
      repeat (4) @(negedge clk);
      dclk = 1'b0;
      repeat (4) @(negedge clk);
      if (i == 0) check("R3", "dvalid_n after first dclk fall", 64'(dvalid_n), 64'd1);
    end
    chain_in = 1'b0;
  endtask

  function automatic int mism_tdm(input int n, input int w);
    int m = 0;
    for (int i = 0; i < n; i++)
      if (cap[i][0] !== wv[i/w][15 - (i%w)]) m++;
    return m;
  endfunction

  function automatic int mism_par(input int n, input int w);
    int m = 0;
    for (int l = 0; l < 4; l++)
      for (int i = 0; i < n; i++)
        if (cap[i][l] !== wv[4*l + i/w][15 - (i%w)]) m++;
    return m;
  endfunction

  function automatic int upper_ones(input int lo, input int hi);
    int m = 0;
    for (int i = lo; i < hi; i++) if (cap[i][3:1] !== 3'b000) m++;
    return m;
  endfunction

  function automatic int chain_mism(input int base, input int n, input logic [31:0] src);
    int m = 0;
    for (int j = 0; j < n; j++) if (cap[base+j][0] !== src[31-j]) m++;
    return m;
  endfunction

  task automatic t_reset();
    check("R1", "dvalid_n at reset", 64'(dvalid_n), 64'd1);
    check("R1", "dout at reset", 64'(dout), 64'd0);
    check("R1", "overrun at reset", 64'(overrun), 64'd0);
  endtask

  task automatic t_tdm16();
    logic [31:0] src = 32'hc3a5_0000;
    set_words(16'h1357);
    wv[0] = 16'h0492; wv[15] = 16'hffff;
    load_results(1'b0, 2'b00);
    check("R4", "first bit before any dclk", 64'(dout[0]), 64'(wv[0][15]));
    read_bits(272, src);
    check("R4", "tdm 16-bit stream mismatches", 64'(mism_tdm(256, 16)), 64'd0);
    check("R4", "upper outputs in tdm", 64'(upper_ones(0, 272)), 64'd0);
    check("R7", "chain bits after 256 local", 64'(chain_mism(256, 16, src)), 64'd0);
    repeat (20) @(negedge clk);
    check("R3", "dvalid_n stays high", 64'(dvalid_n), 64'd1);
  endtask

  task automatic t_par16();
    set_words(16'h2468);
    load_results(1'b1, 2'b00);
    read_bits(72, 32'hffff_ffff);
    check("R5", "parallel 16-bit lanes mismatches", 64'(mism_par(64, 16)), 64'd0);
    for (int i = 64; i < 72; i++) check("R8", "outputs after parallel data, chain high", 64'(cap[i]), 64'd0);
  endtask

  task automatic t_tdm14();
    logic [31:0] src = 32'hb700_0000;
    set_words(16'h9e37);
    load_results(1'b0, 2'b01);
    read_bits(232, src);
    check("R6", "tdm 14-bit stream mismatches", 64'(mism_tdm(224, 14)), 64'd0);
    check("R7", "chain bits after 224 local", 64'(chain_mism(224, 8, src)), 64'd0);
  endtask

  task automatic t_par12();
    set_words(16'h7f4a);
    load_results(1'b1, 2'b11);
    read_bits(48, 32'h0);
    check("R6", "parallel 12-bit (code 11) mismatches", 64'(mism_par(48, 12)), 64'd0);
  endtask

  task automatic t_cfg();
    logic [15:0] w = 16'hb460;
    logic [15:0] got = '0;
    load_cfg(w);
    read_bits(16, 32'h0);
    for (int i = 0; i < 16; i++) got[15-i] = cap[i][0];
    check("R9", "config readback word", 64'(got), 64'(w));
    check("R9", "upper outputs during readback", 64'(upper_ones(0, 16)), 64'd0);
    load_cfg(16'h8c10);
    set_words(16'h0bad);
    load_results(1'b0, 2'b10);
    read_bits(192, 32'h0);
    check("R9", "results replace unread config", 64'(mism_tdm(192, 12)), 64'd0);
    check("R6", "tdm 12-bit (code 10) stream", 64'(mism_tdm(192, 12)), 64'd0);
  endtask

  task automatic t_overrun();
    set_words(16'h3141);
    load_results(1'b0, 2'b00);
    check("R10", "overrun after clean load", 64'(overrun), 64'd0);
    read_bits(10, 32'h0);
    set_words(16'h5926);
    load_results(1'b0, 2'b00);
    check("R10", "overrun after mid-readout load", 64'(overrun), 64'd1);
    read_bits(256, 32'h0);
    check("R10", "restarted stream mismatches", 64'(mism_tdm(256, 16)), 64'd0);
    load_results(1'b0, 2'b00);
    check("R10", "overrun cleared by clean load", 64'(overrun), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_tdm16();
    t_par16();
    t_tdm14();
    t_par12();
    t_cfg();
    t_overrun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule